// File: doc/BRIEF.md
# Single-Slave Two-Wire Bus Master

This block drives a two-wire serial link (a clock line and an open-drain data line) to exactly one slave. Each transaction moves one byte: the master sends a register-address byte and then either sends a data byte or receives one. The frame has no slave address field and no acknowledge bits. An even parity bit follows every byte in both directions. A read is one frame: the master sends the address and then releases the data line, and the slave returns the byte within the same frame.

A host reaches the block through a small register port. The port has an enable, a write strobe, a register index and byte-wide data, and read data returns combinationally. The host loads the address byte, the write-data byte, a direction/length word and the clock divisor, then sets the go bit. The go bit reads back as one until the frame has ended, so software can use it as a busy flag. Completion, parity failure and rejected writes are recorded as sticky flags that are cleared by writing one. One interrupt line combines these flags through per-flag enables and a global enable.

Top module: `twl_master`

Register indices: 0 control (bit0 go/busy, bit1 global interrupt enable), 1 flag enables, 2 flags (bit0 frame done, bit1 parity error, bit2 load-busy), 3 address byte, 4 data byte, 5 direction/length (bit7 read, bits 2:0 length), 6 half-period divisor.

## Requirements
- R1: After reset the clock line is high, the data line is released, control, enables and flags read 0, the divisor reads its reset parameter (120), and the interrupt line is low.
- R2: A write frame is a start (data falls while the clock is high), 19 clock pulses carrying: a direction bit 0, the address MSB first, its parity, the data MSB first, and its parity. A stop follows (data rises while the clock is high). No acknowledge pulse occurs.
- R3: A read frame sends direction bit 1, the address and its parity. The master then releases the data line for 9 pulses and samples it on each pulse. The 8 received bits, MSB first, are stored in the data register.
- R4: Parity is even: each parity bit makes the count of ones across its byte plus itself even. A received parity mismatch sets both the error flag (bit1) and the done flag (bit0).
- R5: Inside a frame the data line changes only while the clock is low. The start and the stop are the only exceptions.
- R6: Writing go (bit0 of control) while idle starts a frame. The go bit reads 1 until the frame ends and then clears by itself, and the done flag is set at that point.
- R7: While a frame is active, writes to the address, data, direction/length or divisor registers are ignored. A control write with go set is also ignored, and its global enable bit is not taken. Each such write sets the load-busy flag (bit2) and does not start a second frame.
- R8: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: The interrupt line is high exactly when the global enable is set and some flag is set together with its enable bit.
- R10: Each half of a clock pulse lasts the divisor value in module clocks, and a divisor of 0 acts as 1.
- R11: The length field and read bit read back as written. A frame always carries exactly one data byte, whatever the length field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Write strobe (with reg_en) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_o | output | 1 | Serial clock line |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_i | input | 1 | Data line level |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 data values through write frames and through read frames, using an address that varies with the value. This catches a byte order slip, a wrong parity sense or a missing turnaround as a corrupted frame or a wrong stored byte. A slave model that sends bad parity must set both the error and the done flags; a design that drops either would leave software waiting or accepting bad data. Register loads during an active frame are checked to leave the frame and the registers untouched and to set load-busy. The clock pulse spacing is measured for divisors 0 to 3, which exposes an off-by-one in the divider or a division by zero.

// File: rtl/twl_pkg.sv
// Shared constants for the two-wire single-slave master.
// Assumes a byte-wide register port; indices and flag positions are
// software-visible and fixed here.
package twl_pkg;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IX_CTRL  = 3'd0;
    localparam logic [IDX_W-1:0] IX_IEN   = 3'd1;
    localparam logic [IDX_W-1:0] IX_STAT  = 3'd2;
    localparam logic [IDX_W-1:0] IX_RADDR = 3'd3;
    localparam logic [IDX_W-1:0] IX_DATA  = 3'd4;
    localparam logic [IDX_W-1:0] IX_LEN   = 3'd5;
    localparam logic [IDX_W-1:0] IX_DIV   = 3'd6;

    localparam int CT_GO  = 0;
    localparam int CT_GIE = 1;

    localparam int ST_DONE = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_LB   = 2;
    localparam int ST_W    = 3;

    localparam int LEN_W = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_LOW,
        SQ_HIGH,
        SQ_STOP_LOW,
        SQ_STOP_HIGH
    } sq_state_e;
endpackage

// File: rtl/twl_clkdiv.sv
// Half-period tick generator.
// Emits a one-cycle tick every max(div,1) module clocks while run is high;
// the count restarts whenever run is low. Assumes div is stable while run.
module twl_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // effective divisor: zero behaves as one
    assign lim  = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
    assign tick = run && (cnt == lim - 1'b1);

    // count module clocks within one half period
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    a_r10_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim));
endmodule

// File: rtl/twl_seq.sv
// Bit-level frame sequencer.
// On launch it shifts out: start, direction, address+parity, then either
// data+parity (write) or samples 9 bits from the line (read), then stop.
// Advances one half period per tick. Assumes inputs hold while active.
module twl_seq
    import twl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              rd,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_oe,
    output logic              active,
    output logic              done,
    output logic              par_err,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int FRAME_BITS = 1 + 2 * (BYTE_W + 1);
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int RX_FIRST   = 2 + BYTE_W;
    localparam int RX_W       = BYTE_W + 1;

    sq_state_e             state;
    logic [BIT_W-1:0]      bitn;
    logic [FRAME_BITS-1:0] tx;
    logic [RX_W-1:0]       rx;
    logic                  rd_q;
    logic                  rx_phase;
    logic                  last_bit;

    assign rx_phase = rd_q && (bitn >= BIT_W'(RX_FIRST));
    assign last_bit = (bitn == BIT_W'(FRAME_BITS - 1));
    assign active   = (state != SQ_IDLE);

    // line drive decoded from the frame position
    always_comb begin
        scl_o  = !((state == SQ_LOW) || (state == SQ_STOP_LOW));
        sda_oe = 1'b0;
        case (state)
            SQ_START, SQ_STOP_LOW, SQ_STOP_HIGH: sda_oe = 1'b1;
            SQ_LOW, SQ_HIGH:                     sda_oe = rx_phase ? 1'b0 : !tx[FRAME_BITS-1];
            default:                             sda_oe = 1'b0;
        endcase
    end

    // frame state machine, one step per half-period tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            bitn    <= '0;
            tx      <= '0;
            rx      <= '0;
            rd_q    <= 1'b0;
            done    <= 1'b0;
            par_err <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (launch) begin
                        state <= SQ_START;
                        bitn  <= '0;
                        rd_q  <= rd;
                        tx    <= {rd, addr, ^addr, wdata, ^wdata};
                        rx    <= '0;
                    end
                end
                SQ_START: if (tick) state <= SQ_LOW;
                SQ_LOW:   if (tick) state <= SQ_HIGH;
                SQ_HIGH: begin
                    if (tick) begin
                        if (rx_phase) rx <= {rx[RX_W-2:0], sda_i};
                        if (last_bit) begin
                            state <= SQ_STOP_LOW;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            tx    <= {tx[FRAME_BITS-2:0], 1'b0};
                            state <= SQ_LOW;
                        end
                    end
                end
                SQ_STOP_LOW: if (tick) state <= SQ_STOP_HIGH;
                SQ_STOP_HIGH: begin
                    if (tick) begin
                        state   <= SQ_IDLE;
                        done    <= 1'b1;
                        par_err <= rd_q && (^rx);
                        rx_byte <= rx[RX_W-1:1];
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R5: data steady through every clock-high half of a bit
    a_r5_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HIGH && scl_o && $past(scl_o)) |-> $stable(sda_oe));
    // R2: the stop is reached only after the last frame bit
    a_r2_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_STOP_LOW) |-> last_bit);
    // R4: a write frame never reports a parity failure
    a_r4_no_err_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_q) |-> !par_err);
    // R1: idle leaves the clock high and the data line released
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (scl_o && !sda_oe));
endmodule

// File: rtl/twl_regs.sv
// Register file, load-busy guard, sticky flags and interrupt combine.
// Assumes one access per cycle; reads are combinational. A launch pulse
// goes to the sequencer one cycle after go is accepted.
module twl_regs
    import twl_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DIV_RESET = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              seq_done,
    input  logic              seq_perr,
    input  logic [BYTE_W-1:0] seq_rx,
    output logic              launch,
    output logic              rd_q,
    output logic [BYTE_W-1:0] addr_q,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] div_q,
    output logic              irq
);
    logic              busy;
    logic              gie;
    logic [ST_W-1:0]   ien;
    logic [ST_W-1:0]   stat;
    logic [ST_W-1:0]   stat_set;
    logic [ST_W-1:0]   stat_clr;
    logic [LEN_W-1:0]  len_q;
    logic              wr;
    logic              guarded;
    logic              blocked;

    assign wr = reg_en && reg_we;

    // which writes must not land while a frame runs
    always_comb begin
        guarded = (reg_idx == IX_RADDR) || (reg_idx == IX_DATA) ||
                  (reg_idx == IX_LEN)   || (reg_idx == IX_DIV)  ||
                  ((reg_idx == IX_CTRL) && reg_wdata[CT_GO]);
        blocked = wr && busy && guarded;
    end

    // flag set and write-one-clear sources
    always_comb begin
        stat_set          = '0;
        stat_set[ST_DONE] = seq_done;
        stat_set[ST_ERR]  = seq_done && seq_perr;
        stat_set[ST_LB]   = blocked;
        stat_clr          = (wr && reg_idx == IX_STAT) ? reg_wdata[ST_W-1:0] : '0;
    end

    // sticky flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~stat_clr) | stat_set;
    end

    // configuration registers and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie    <= 1'b0;
            ien    <= '0;
            addr_q <= '0;
            data_q <= '0;
            len_q  <= '0;
            rd_q   <= 1'b0;
            div_q  <= BYTE_W'(DIV_RESET);
        end else begin
            if (wr && !blocked) begin
                case (reg_idx)
                    IX_CTRL:  gie    <= reg_wdata[CT_GIE];
                    IX_IEN:   ien    <= reg_wdata[ST_W-1:0];
                    IX_RADDR: addr_q <= reg_wdata;
                    IX_DATA:  data_q <= reg_wdata;
                    IX_LEN: begin
                        len_q <= reg_wdata[LEN_W-1:0];
                        rd_q  <= reg_wdata[BYTE_W-1];
                    end
                    IX_DIV:   div_q  <= reg_wdata;
                    default: ;
                endcase
            end
            if (seq_done && rd_q) data_q <= seq_rx;
        end
    end

    // go bit: set by host, cleared by frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            launch <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (seq_done) begin
                busy <= 1'b0;
            end else if (wr && !busy && reg_idx == IX_CTRL && reg_wdata[CT_GO]) begin
                busy   <= 1'b1;
                launch <= 1'b1;
            end
        end
    end

    assign irq = gie && |(stat & ien);

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            IX_CTRL: begin
                reg_rdata[CT_GO]  = busy;
                reg_rdata[CT_GIE] = gie;
            end
            IX_IEN:   reg_rdata[ST_W-1:0] = ien;
            IX_STAT:  reg_rdata[ST_W-1:0] = stat;
            IX_RADDR: reg_rdata = addr_q;
            IX_DATA:  reg_rdata = data_q;
            IX_LEN: begin
                reg_rdata[LEN_W-1:0]  = len_q;
                reg_rdata[BYTE_W-1]   = rd_q;
            end
            IX_DIV:   reg_rdata = div_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R6: go stays set until the sequencer reports the end
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> busy);
    // R7: an address load during a frame raises load-busy
    a_r7_lb_on_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy && reg_idx == IX_RADDR) |=> stat[ST_LB]);
    // R7: the address held for the sequencer is frozen while busy
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));
    // R8: done flag persists unless a one is written to its bit
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_DONE] && !(wr && reg_idx == IX_STAT && reg_wdata[ST_DONE])) |=> stat[ST_DONE]);
endmodule

// File: rtl/twl_master.sv
// Top of the single-slave two-wire master: register file, half-period
// divider and frame sequencer. The data line is open drain: sda_oe pulls
// it low, an external pull-up makes it high.
module twl_master
    import twl_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DIV_RESET = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              scl_o,
    output logic              sda_oe,
    input  logic              sda_i,
    output logic              irq
);
    logic              launch;
    logic              rd_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] div_q;
    logic              active;
    logic              tick;
    logic              done;
    logic              perr;
    logic [BYTE_W-1:0] rx_byte;

    twl_regs #(.BYTE_W(BYTE_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_done(done), .seq_perr(perr), .seq_rx(rx_byte),
        .launch(launch), .rd_q(rd_q), .addr_q(addr_q), .data_q(data_q),
        .div_q(div_q), .irq(irq)
    );

    twl_clkdiv #(.DIV_W(BYTE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(active), .div(div_q), .tick(tick)
    );

    twl_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .rd(rd_q),
        .addr(addr_q), .wdata(data_q), .tick(tick), .sda_i(sda_i),
        .scl_o(scl_o), .sda_oe(sda_oe), .active(active), .done(done),
        .par_err(perr), .rx_byte(rx_byte)
    );
endmodule

// File: tb/test_twl_master.sv
module test_twl_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_idx = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_o, sda_oe, irq;
    logic       slv_low = 1'b0;
    wire        sda_line = !(sda_oe || slv_low);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    twl_master i_twl_master (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line), .irq(irq)
    );

    // slave model and line monitor, sampled on the falling clock edge
    int          cyc = 0, last_rise = 0, per = 0, pmin = 0, pmax = 0;
    int          rises = 0, frames = 0, illegal = 0;
    bit          inframe = 0, dir = 0, p_scl = 1, p_sda = 1;
    logic [18:0] sh = '0;
    logic [7:0]  slv_data = 8'h00;
    bit          slv_bad = 0;
    logic [8:0]  resp;

    always @(negedge clk) begin
        cyc++;
        resp = {slv_data, (^slv_data) ^ slv_bad};
        if (rst_n && scl_o && p_scl && (sda_line != p_sda)) begin
            if (!sda_line) begin
                if (inframe) illegal++;
                inframe = 1; rises = 0; sh = '0; pmin = 1 << 20; pmax = 0;
            end else begin
                if (!inframe) illegal++;
                else begin inframe = 0; frames++; end
            end
        end
        if (scl_o && !p_scl && inframe) begin
            if (rises == 0) dir = sda_line;
            if (rises < 19) sh = {sh[17:0], sda_line};
            if (rises > 0) begin
                per = cyc - last_rise;
                if (per < pmin) pmin = per;
                if (per > pmax) pmax = per;
            end
            last_rise = cyc;
            rises++;
        end
        if (!scl_o && p_scl)
            slv_low = inframe && dir && rises >= 10 && rises <= 18 && !resp[18 - rises];
        p_scl = scl_o;
        p_sda = sda_line;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [7:0] v);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_idx = idx; reg_wdata = v;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [7:0] v);
        @(negedge clk);
        reg_idx = idx;
        #1 v = reg_rdata;
    endtask

    bit gie_sh = 0;

    task automatic start_xfer(input bit rd, input logic [7:0] a, input logic [7:0] d);
        wr_reg(3'd3, a);
        wr_reg(3'd4, d);
        wr_reg(3'd5, {rd, 4'b0, 3'd1});
        wr_reg(3'd0, {6'b0, gie_sh, 1'b1});
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int n = 0;
        do begin
            rd_reg(3'd0, v);
            n++;
        end while (v[0] && n < 20000);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] a;
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(scl_o && !sda_oe && !irq, "R1 lines", {scl_o, sda_oe, irq}, 3'b100);
        rd_reg(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd_reg(3'd1, v); chk(v == 0, "R1 ien", v, 0);
        rd_reg(3'd2, v); chk(v == 0, "R1 flags", v, 0);
        rd_reg(3'd6, v); chk(v == 120, "R1 divisor", v, 120);

        // R2/R4/R5/R6 write sweep over every data value
        wr_reg(3'd6, 8'd1);
        for (int d = 0; d < 256; d++) begin
            a = 8'(d) ^ 8'h5A;
            f0 = frames;
            start_xfer(1'b0, a, 8'(d));
            wait_idle();
            chk(sh == {1'b0, a, ^a, 8'(d), ^8'(d)}, "R2 write frame", sh, {1'b0, a, ^a, 8'(d), ^8'(d)});
            chk(frames == f0 + 1 && rises == 20, "R2 pulse count", rises, 20);
            chk(illegal == 0, "R5 data change with clock high", illegal, 0);
            rd_reg(3'd2, v); chk(v == 3'b001, "R6 done flag", v, 1);
            wr_reg(3'd2, 8'h07);
        end

        // R3/R4 read sweep
        for (int d = 0; d < 256; d++) begin
            a = 8'(d) + 8'd17;
            slv_data = 8'(255 - d);
            start_xfer(1'b1, a, 8'hFF);
            wait_idle();
            chk(sh[18:9] == {1'b1, a, ^a}, "R3 read header", sh[18:9], {1'b1, a, ^a});
            rd_reg(3'd4, v); chk(v == 8'(255 - d), "R3 read data", v, 255 - d);
            rd_reg(3'd2, v); chk(v == 3'b001, "R4 good parity", v, 1);
            chk(illegal == 0, "R5 read turnaround", illegal, 0);
            wr_reg(3'd2, 8'h07);
        end

        // R4 bad parity from the slave
        slv_bad = 1; slv_data = 8'hC3;
        start_xfer(1'b1, 8'h20, 8'h00);
        wait_idle();
        rd_reg(3'd2, v); chk(v == 3'b011, "R4 parity error flags", v, 3);
        slv_bad = 0;
        wr_reg(3'd2, 8'h07);

        // R10 divisor timing
        for (int dv = 0; dv < 4; dv++) begin
            wr_reg(3'd6, 8'(dv));
            start_xfer(1'b0, 8'h81, 8'h7E);
            wait_idle();
            chk(pmin == 2 * ((dv == 0) ? 1 : dv) && pmax == pmin, "R10 pulse period", pmax, 2 * ((dv == 0) ? 1 : dv));
            wr_reg(3'd2, 8'h07);
        end

        // R6/R7 loads during an active frame
        wr_reg(3'd6, 8'd4);
        f0 = frames;
        start_xfer(1'b0, 8'h3C, 8'hA5);
        rd_reg(3'd0, v); chk(v[0] == 1'b1, "R6 go reads busy", v, 1);
        wr_reg(3'd3, 8'h11);
        wr_reg(3'd4, 8'h22);
        wr_reg(3'd6, 8'd9);
        wr_reg(3'd0, 8'h03);
        wait_idle();
        chk(frames == f0 + 1, "R7 single frame", frames - f0, 1);
        chk(sh == {1'b0, 8'h3C, ^8'h3C, 8'hA5, ^8'hA5}, "R7 frame untouched", sh, {1'b0, 8'h3C, ^8'h3C, 8'hA5, ^8'hA5});
        rd_reg(3'd3, v); chk(v == 8'h3C, "R7 address kept", v, 8'h3C);
        rd_reg(3'd4, v); chk(v == 8'hA5, "R7 data kept", v, 8'hA5);
        rd_reg(3'd6, v); chk(v == 8'd4, "R7 divisor kept", v, 4);
        rd_reg(3'd0, v); chk(v == 8'h00, "R7 gie not taken", v, 0);
        rd_reg(3'd2, v); chk(v == 3'b101, "R7 load-busy flag", v, 5);

        // R8 write-one-clear
        wr_reg(3'd2, 8'h00);
        rd_reg(3'd2, v); chk(v == 3'b101, "R8 zero write keeps", v, 5);
        wr_reg(3'd2, 8'h01);
        rd_reg(3'd2, v); chk(v == 3'b100, "R8 clear done only", v, 4);

        // R9 interrupt combine (load-busy flag set)
        wr_reg(3'd0, 8'h02);
        @(negedge clk); chk(!irq, "R9 no enables", irq, 0);
        wr_reg(3'd1, 8'h04);
        @(negedge clk); chk(irq, "R9 enabled flag", irq, 1);
        wr_reg(3'd0, 8'h00);
        @(negedge clk); chk(!irq, "R9 global gate", irq, 0);
        wr_reg(3'd0, 8'h02);
        wr_reg(3'd2, 8'h04);
        @(negedge clk); chk(!irq, "R9 cleared flag", irq, 0);

        // R11 length field readback, frame still one byte
        wr_reg(3'd5, 8'h85);
        rd_reg(3'd5, v); chk(v == 8'h85, "R11 length readback", v, 8'h85);
        wr_reg(3'd5, 8'h06);
        rd_reg(3'd5, v); chk(v == 8'h06, "R11 length readback write", v, 8'h06);
        wr_reg(3'd3, 8'h44);
        wr_reg(3'd4, 8'h99);
        wr_reg(3'd0, 8'h01);
        wait_idle();
        chk(rises == 20 && sh == {1'b0, 8'h44, ^8'h44, 8'h99, ^8'h99}, "R11 one byte frame", rises, 20);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule